// File: doc/BRIEF.md
# HDLC frame transmitter with alternating byte buffers

This block serialises HDLC frames onto a single output line, one bit for each cycle on which the bit-enable strobe is high. Between frames it repeats the 01111110 flag. Software fills two 64-byte banks through a byte write port and then raises the enable level. The frame begins at the next flag boundary with byte 0 of bank 0, continues through the banks in turn, and ends on a programmed byte of whichever bank carries its end mark. A 16-bit check sequence and a closing flag follow the last byte.

A bank's interrupt bit is set when byte 63 of that bank leaves the line, which tells software it can write that bank again while the other bank is being sent. If the enable is withdrawn while data bytes are still being sent, the frame is cut off with an abort byte and the line goes back to flags.

Top module: `hdlc_pp_tx`

## Requirements
- R1: After reset `tx_o` is 1 and `int_o` is 0. While idle the line carries the flag 0x7E repeatedly, most significant bit first, so the first eight bits after reset are 0,1,1,1,1,1,1,0.
- R2: A frame starts only on a flag boundary. At least one complete flag comes first, and the first data bit follows the end of the flag during which `enable_i` was seen high.
- R3: Data bytes are sent least significant bit first. Byte 0 of bank 0 goes first.
- R4: In the data and check-sequence bits, a 0 is inserted after every run of five 1s. Flags and abort bytes get no inserted bits.
- R5: The check sequence is the CRC over the data bytes with polynomial x^16+x^12+x^5+1, reflected, starting from 0xFFFF. It is sent complemented, low bit first, and a closing flag follows it.
- R6: After the last byte of a bank, sending moves to byte 0 of the other bank. The frame's last byte is the first byte whose index equals `end_idx_i` in a bank whose end mark (`end0_i` or `end1_i`) is 1. The mark is sampled while that bank is being sent.
- R7: Sending byte 63 of bank b sets `int_o[b]`. Writing 1 to `int_clr_i[b]` clears that bit, and a set on the same cycle wins. A bit is not changed by a clear of the other bit.
- R8: If `enable_i` is low on a strobe step during the data bytes, the frame stops and 0x7F is sent MSB first, followed by flags.
- R9: `tx_o` changes only on the cycle after one on which `bit_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for a bank byte |
| wr_buf_i | input | 1 | Bank selected for the write |
| wr_addr_i | input | 6 | Byte index of the write |
| wr_data_i | input | 8 | Byte value to write |
| enable_i | input | 1 | Frame enable level |
| end0_i | input | 1 | End mark for bank 0 |
| end1_i | input | 1 | End mark for bank 1 |
| end_idx_i | input | 6 | Index of the last byte in a marked bank |
| int_clr_i | input | 2 | Write-one-to-clear for the bank interrupts |
| bit_en_i | input | 1 | Bit step strobe |
| tx_o | output | 1 | Serial line |
| int_o | output | 2 | Bank-empty interrupt bits |

## Verification
Each output bit is registered, so it appears one clock after the strobe cycle that produces it. The bench samples `tx_o` at the falling edge that follows each strobed rising edge, and it checks on every unstrobed cycle that the line has not moved. The bench records the whole line and decodes it offline: it finds the frame boundary, removes the inserted zeros, and compares the bytes, the check sequence and the closing flag or abort byte with a frame it builds from the bank contents and the end rule. An interrupt bit or a clear takes effect one clock after its cause, so the bench reads `int_o` at the falling edge after the clear pulse, and after the whole frame for bits set by byte 63.

// File: rtl/hdlc_pp_pkg.sv
package hdlc_pp_pkg;
  typedef enum logic [1:0] {ST_FLAG, ST_DATA, ST_FCS, ST_ABORT} tx_state_e;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'h7F;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam int          RUN_MAX    = 5;
endpackage

// File: rtl/hdlc_pp_mem.sv
module hdlc_pp_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic          wr_buf_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_buf_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [2][DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_buf_i][wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_buf_i][rd_addr_i];
endmodule

// File: rtl/hdlc_pp_crc16.sv
module hdlc_pp_crc16 import hdlc_pp_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb = crc_q[0] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= {1'b0, crc_q[15:1]} ^ (fb ? CRC_POLY_R : 16'h0000);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdlc_pp_tx.sv
module hdlc_pp_tx import hdlc_pp_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_buf_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          enable_i,
  input  logic          end0_i,
  input  logic          end1_i,
  input  logic [AW-1:0] end_idx_i,
  input  logic [1:0]    int_clr_i,
  input  logic          bit_en_i,
  output logic          tx_o,
  output logic [1:0]    int_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  tx_state_e     state_q, state_d;
  logic [4:0]    cnt_q, cnt_d;
  logic          buf_q, buf_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [2:0]    ones_q, ones_d;
  logic          tx_q, tx_d;
  logic [1:0]    int_q, int_set;
  logic [7:0]    cur_byte;
  logic [15:0]   crc;
  logic          cur_bit, fcs_bit, crc_init, crc_en;
  logic [1:0]    end_mark;

  hdlc_pp_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk_i, .wr_en_i, .wr_buf_i, .wr_addr_i, .wr_data_i,
    .rd_buf_i(buf_q), .rd_addr_i(idx_q), .rd_data_o(cur_byte)
  );

  hdlc_pp_crc16 u_crc (
    .clk_i, .rst_ni, .init_i(crc_init), .en_i(crc_en), .bit_i(cur_bit), .crc_o(crc)
  );

  assign end_mark = {end1_i, end0_i};
  assign cur_bit  = cur_byte[cnt_q[2:0]];
  assign fcs_bit  = ~crc[cnt_q[3:0]];

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    buf_d    = buf_q;
    idx_d    = idx_q;
    ones_d   = ones_q;
    tx_d     = tx_q;
    crc_init = 1'b0;
    crc_en   = 1'b0;
    int_set  = 2'b00;
    if (bit_en_i) begin
      unique case (state_q)
        ST_FLAG: begin
          tx_d = FLAG_BYTE[~cnt_q[2:0]];
          if (cnt_q[2:0] == 3'd7) begin
            cnt_d = '0;
            if (enable_i) begin
              state_d  = ST_DATA;
              buf_d    = 1'b0;
              idx_d    = '0;
              ones_d   = '0;
              crc_init = 1'b1;
            end
          end else cnt_d = cnt_q + 5'd1;
        end
        ST_ABORT: begin
          tx_d = ABORT_BYTE[~cnt_q[2:0]];
          if (cnt_q[2:0] == 3'd7) begin
            state_d = ST_FLAG;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 5'd1;
        end
        ST_DATA: begin
          if (!enable_i) begin
            // first abort bit goes out on the withdrawal step
            state_d = ST_ABORT;
            tx_d    = ABORT_BYTE[7];
            cnt_d   = 5'd1;
            ones_d  = '0;
          end else if (ones_q == 3'(RUN_MAX)) begin
            tx_d   = 1'b0;
            ones_d = '0;
          end else begin
            tx_d   = cur_bit;
            ones_d = cur_bit ? ones_q + 3'd1 : 3'd0;
            crc_en = 1'b1;
            if (cnt_q[2:0] == 3'd7) begin
              cnt_d = '0;
              if (idx_q == LAST_IDX) int_set[buf_q] = 1'b1;
              if (end_mark[buf_q] && idx_q == end_idx_i) state_d = ST_FCS;
              else if (idx_q == LAST_IDX) begin
                buf_d = ~buf_q;
                idx_d = '0;
              end else idx_d = idx_q + 1'b1;
            end else cnt_d = cnt_q + 5'd1;
          end
        end
        default: begin  // ST_FCS
          if (ones_q == 3'(RUN_MAX)) begin
            tx_d   = 1'b0;
            ones_d = '0;
            if (cnt_q == 5'd16) begin
              state_d = ST_FLAG;
              cnt_d   = '0;
            end
          end else begin
            tx_d   = fcs_bit;
            ones_d = fcs_bit ? ones_q + 3'd1 : 3'd0;
            if (cnt_q >= 5'd15) begin
              // a trailing stuff bit must precede the closing flag
              if (ones_d == 3'(RUN_MAX)) cnt_d = 5'd16;
              else begin
                state_d = ST_FLAG;
                cnt_d   = '0;
              end
            end else cnt_d = cnt_q + 5'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FLAG;
      cnt_q   <= '0;
      buf_q   <= 1'b0;
      idx_q   <= '0;
      ones_q  <= '0;
      tx_q    <= 1'b1;
      int_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      buf_q   <= buf_d;
      idx_q   <= idx_d;
      ones_q  <= ones_d;
      tx_q    <= tx_d;
      int_q   <= (int_q & ~int_clr_i) | int_set;
    end
  end

  assign tx_o  = tx_q;
  assign int_o = int_q;
endmodule

// File: rtl/hdlc_pp_chk.sv
module hdlc_pp_chk import hdlc_pp_pkg::*; (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       enable_i,
  input logic [1:0] int_clr_i,
  input logic       tx_o,
  input logic [1:0] int_o,
  input tx_state_e  state_q,
  input logic [2:0] ones_q
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(tx_o));

  assert_int0_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o[0] && !int_clr_i[0] |=> int_o[0]);

  assert_int1_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o[1] && !int_clr_i[1] |=> int_o[1]);

  assert_int_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_i[1] && !bit_en_i |=> !int_o[1]);

  assert_run_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= 3'(RUN_MAX));

  assert_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA && bit_en_i && !enable_i |=> state_q == ST_ABORT && !tx_o);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FLAG && bit_en_i && !enable_i |=> state_q == ST_FLAG);
endmodule

bind hdlc_pp_tx hdlc_pp_chk u_chk (
  .clk_i, .rst_ni, .bit_en_i, .enable_i, .int_clr_i, .tx_o, .int_o, .state_q, .ones_q
);

// File: tb/hdlc_pp_tx_tb.sv
module hdlc_pp_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, wr_buf_i = 1'b0;
  logic [5:0] wr_addr_i = '0, end_idx_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       en_req = 1'b0, dropped = 1'b0;
  logic       enable_i;
  logic       end0_i = 1'b0, end1_i = 1'b0;
  logic [1:0] int_clr_i = '0;
  logic       bit_en_i = 1'b0;
  logic       tx_o;
  logic [1:0] int_o;

  int  checks = 0, errors = 0, ncap = 0, period = 1, phase = 0, drop_at = 0;
  int  hold_err = 0, en_idx = 0;
  bit  cap [8192];
  bit  dbits [8192];
  logic [7:0] exp_b [512];
  int  exp_n;
  logic last_tx = 1'b1;

  assign enable_i = en_req & ~dropped;

  always #10 clk_i = ~clk_i;

  hdlc_pp_tx dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_buf_i, .wr_addr_i, .wr_data_i, .enable_i,
    .end0_i, .end1_i, .end_idx_i, .int_clr_i, .bit_en_i, .tx_o, .int_o
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      ncap = 0; phase = 0; bit_en_i = 1'b0; last_tx = 1'b1; dropped = 1'b0;
    end else begin
      if (bit_en_i) begin
        if (ncap < 8192) cap[ncap] = tx_o;
        ncap++;
      end else if (tx_o !== last_tx) hold_err++;
      last_tx = tx_o;
      if (!en_req) dropped = 1'b0;
      else if (drop_at != 0 && ncap >= drop_at) dropped = 1'b1;
      phase++;
      bit_en_i = ((phase % period) == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int a, input int s);
    if ((a % 5) == 0) return 8'hFF;
    return 8'(a * 37 + b * 91 + s * 13 + 11);
  endfunction

  function automatic logic [15:0] crc_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ exp_b[k][b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return ~c;
  endfunction

  function automatic bit is_flag(input int i);
    logic [7:0] v = '0;
    for (int k = 0; k < 8; k++) v = {v[6:0], cap[i + k]};
    return v == 8'h7E;
  endfunction

  task automatic wr(input bit b, input int a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_buf_i = b; wr_addr_i = 6'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic fill(input bit b, input int s);
    for (int a = 0; a < 64; a++) wr(b, a, pat(int'(b), a, s));
  endtask

  task automatic add_exp(input int b, input int first, input int last, input int s);
    for (int a = first; a <= last; a++) begin exp_b[exp_n] = pat(b, a, s); exp_n++; end
  endtask

  task automatic do_reset(input int per);
    en_req = 1'b0; drop_at = 0;
    @(negedge clk_i); rst_ni = 1'b0; period = per;
    repeat (3) @(negedge clk_i);
    chk(tx_o == 1'b1 && int_o == 2'b00, "R1", "reset tx/int", {tx_o, int_o}, 4);
    rst_ni = 1'b1;
  endtask

  task automatic start_frame(input int drop);
    repeat (5) @(negedge clk_i);
    en_idx = ncap;
    drop_at = en_idx + drop;
    en_req = 1'b1;
  endtask

  task automatic wait_bits(input int n);
    while (ncap < n) @(negedge clk_i);
  endtask

  task automatic decode(output int start, output int nby, output bit abt, output int endpos, output int stuffs);
    int i = 0, nb = 0, ones = 0;
    while (i + 8 <= ncap && is_flag(i)) i += 8;
    start = i; stuffs = 0; abt = 0; endpos = -1;
    for (int j = start; j < ncap; j++) begin
      if (cap[j]) begin
        ones++;
        if (ones == 6) begin
          nb -= 6; endpos = j; abt = (j + 1 < ncap) ? cap[j + 1] : 1'b0;
          break;
        end
        dbits[nb] = 1'b1; nb++;
      end else begin
        if (ones == 5) stuffs++;
        else begin dbits[nb] = 1'b0; nb++; end
        ones = 0;
      end
    end
    nby = (nb < 0) ? 0 : nb / 8;
  endtask

  function automatic logic [7:0] dbyte(input int k);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = dbits[8 * k + b];
    return v;
  endfunction

  task automatic check_frame(input string tag);
    int st, nby, ep, stf, bad;
    bit abt;
    logic [15:0] fcs;
    decode(st, nby, abt, ep, stf);
    chk(is_flag(0), "R1", {tag, " first idle byte"}, int'(cap[0]), 0);
    chk(st >= 8 && st % 8 == 0 && st <= en_idx + 16, "R2", {tag, " frame start"}, st, en_idx);
    chk(!abt && ep > 0 && nby == exp_n + 2, "R6", {tag, " byte count"}, nby, exp_n + 2);
    bad = 0;
    for (int k = 0; k < exp_n && k < nby; k++)
      if (dbyte(k) !== exp_b[k]) begin
        if (bad == 0) $display("FAIL R3 %s byte %0d actual=%0d expected=%0d", tag, k, dbyte(k), exp_b[k]);
        bad++;
      end
    checks++; if (bad != 0) errors++;
    fcs = crc_of(exp_n);
    chk({dbyte(exp_n + 1), dbyte(exp_n)} == fcs, "R5", {tag, " check sequence"},
        int'({dbyte(exp_n + 1), dbyte(exp_n)}), int'(fcs));
    chk(ep > 0 && cap[ep + 1] == 1'b0, "R5", {tag, " closing flag"}, int'(cap[ep + 1]), 0);
    chk(stf > 0, "R4", {tag, " zero insertion seen"}, stf, 1);
  endtask

  initial begin
    int st, nby, ep, stf, bad, ap;
    bit abt;
    fill(1'b0, 0);
    fill(1'b1, 0);

    // T1: single bank, short frame, strobe every cycle
    do_reset(1);
    chk(cap[0] == 1'b0 || ncap == 0, "R9", "no step before strobe", ncap, 0);
    end0_i = 1'b1; end1_i = 1'b0; end_idx_i = 6'd3;
    exp_n = 0; add_exp(0, 0, 3, 0);
    start_frame(16 + ((exp_n + 2) * 48) / 5 + 24);
    wait_bits(drop_at + 48); en_req = 1'b0;
    check_frame("T1");

    // T2: bank 0 full, bank 1 ends at byte 5, strobe every second cycle
    do_reset(2);
    end0_i = 1'b0; end1_i = 1'b1; end_idx_i = 6'd5;
    exp_n = 0; add_exp(0, 0, 63, 0); add_exp(1, 0, 5, 0);
    start_frame(16 + ((exp_n + 2) * 48) / 5 + 24);
    wait_bits(drop_at + 48); en_req = 1'b0;
    check_frame("T2");
    chk(int_o == 2'b01, "R7", "T2 bank interrupts", int_o, 1);

    // write-one-to-clear
    @(negedge clk_i); int_clr_i = 2'b10; @(negedge clk_i); int_clr_i = 2'b00;
    chk(int_o == 2'b01, "R7", "clear of other bit", int_o, 1);
    int_clr_i = 2'b01; @(negedge clk_i); int_clr_i = 2'b00;
    chk(int_o == 2'b00, "R7", "clear bit 0", int_o, 0);

    // T3: bank 0 refilled while bank 1 is sent, then end mark set on bank 0
    do_reset(1);
    end0_i = 1'b0; end1_i = 1'b0; end_idx_i = 6'd2;
    exp_n = 0; add_exp(0, 0, 63, 0); add_exp(1, 0, 63, 0); add_exp(0, 0, 2, 1);
    start_frame(16 + ((exp_n + 2) * 48) / 5 + 24);
    while (!int_o[0]) @(negedge clk_i);
    chk(int_o == 2'b01, "R7", "T3 bank 0 empty first", int_o, 1);
    fill(1'b0, 1);
    end0_i = 1'b1;
    int_clr_i = 2'b01; @(negedge clk_i); int_clr_i = 2'b00;
    wait_bits(drop_at + 48); en_req = 1'b0;
    check_frame("T3");
    chk(int_o == 2'b10, "R7", "T3 bank interrupts", int_o, 2);

    // T4: enable withdrawn mid-data, strobe every third cycle
    fill(1'b0, 0);
    do_reset(3);
    end0_i = 1'b0; end1_i = 1'b1; end_idx_i = 6'd63;
    exp_n = 0; add_exp(0, 0, 63, 0);
    start_frame(16 + 100);
    wait_bits(drop_at + 48); en_req = 1'b0;
    decode(st, nby, abt, ep, stf);
    chk(abt, "R8", "seventh one of abort", int'(abt), 1);
    ap = ep - 6;
    chk(ap > 0 && cap[ap] == 1'b0 && !is_flag(ap) && is_flag(ap + 8) && is_flag(ap + 16),
        "R8", "abort byte then flags", ap, drop_at);
    bad = 0;
    for (int k = 0; k < nby; k++) if (dbyte(k) !== exp_b[k]) bad++;
    chk(bad == 0 && nby > 0, "R8", "bytes before abort", bad, 0);
    chk(hold_err == 0, "R9", "line held between strobes", hold_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule